// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves through a ring of transmit descriptors held in system memory. It starts when software writes the poll register. Each descriptor takes 16 bytes. The walker reads the control word first. While the hardware-ownership flag in that word is set, it also reads the length/flag word and the buffer pointer. It then offers the frame length and buffer address to a downstream transmit stub over a valid/ready handshake. After that it writes the control word back with the ownership flag cleared, which returns the descriptor to software. Finally it moves on to the next descriptor slot.

A descriptor whose ring-end flag is set sends the walker back to the ring base register after that descriptor. When the walker reaches a descriptor owned by software, it stops at that slot and pulses `done`. The next poll resumes from that same slot. Short frames are raised to the minimum frame size. A length of zero, or a length larger than a buffer can hold, is not handed on, but the descriptor is still returned.

Top module: `txr_ring_walker`

## Requirements
- R1: After reset the walker is idle: `mem_req`, `tx_valid` and `done` are all low.
- R2: A configuration write with `cfg_sel`=1 (poll) starts a walk at the current slot, whatever the data. A write with `cfg_sel`=0 loads the ring base with its low 4 bits forced to zero. While idle, that write also moves the current slot to the new base.
- R3: If control word bit 31 (owner) reads 0, the walker stops at that slot, writes nothing, and pulses `done` for exactly one cycle.
- R4: For an owned descriptor, the walker reads slot+0, then slot+4, then slot+8. It raises `tx_valid` with `tx_len`, `tx_addr` (the word at slot+8), `tx_first` (bit 29 of slot+4) and `tx_last` (bit 28 of slot+4). These outputs hold steady until `tx_ready` is high.
- R5: A length (bits 10:0 of slot+4) from 1 to 59 is presented as 60. Lengths from 60 to 1536 are presented unchanged.
- R6: A length of 0, or a length above 1536, skips the handoff: `tx_valid` never rises for that descriptor.
- R7: After the handoff or the skip, the walker writes the control word back to slot+0 with bit 31 cleared and every other bit kept.
- R8: After the write-back, the next slot is slot+16. If bit 31 of slot+4 (ring end) was set, the next slot is the ring base instead.
- R9: A poll that arrives during a walk is remembered, including one that arrives in the cycle a software-owned control word is examined. In that case the walker reads the same slot again instead of stopping, and `done` pulses only on a stop with no poll pending.
- R10: A base write during a walk does not move the current slot. The new base is used at the next ring-end wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = ring base, 1 = poll |
| cfg_wdata | input | AW | Configuration write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Frame offered to the transmit stub |
| tx_ready | input | 1 | Transmit stub accepts the frame |
| tx_len | output | LEN_W | Frame length after padding |
| tx_addr | output | AW | Frame buffer address |
| tx_first | output | 1 | First-segment flag |
| tx_last | output | 1 | Last-segment flag |
| done | output | 1 | One-cycle pulse when the walk stops |

## Verification
A poll demand and the decision to stop on a software-owned control word can fall in the same cycle. The bench sets this up by watching the memory port for the read of a software-owned slot, then driving the poll in exactly the cycle after it, when the returned word is examined. It judges the outcome by counting reads of that slot's control word, which should be two, and `done` pulses, which should be one. A second case stalls the handoff with `tx_ready` low, issues a poll during the stall, and expects the same reread.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int DW = 32;
   localparam int OFS_CTL = 0;
   localparam int OFS_LEN = 4;
   localparam int OFS_BUF = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_CTL,
      ST_CHK_CTL,
      ST_RD_LEN,
      ST_GET_LEN,
      ST_RD_BUF,
      ST_GET_BUF,
      ST_SEND,
      ST_RETURN
   } txr_state_e;
endpackage

// File: rtl/txr_len_chk.sv
module txr_len_chk #(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 60,
   parameter int MAX_LEN = 1536,
   parameter bit PAD_EN  = 1'b1
) (
   input  logic [LEN_W-1:0] raw_len,
   output logic             len_ok,
   output logic [LEN_W-1:0] eff_len
);
   localparam logic [LEN_W-1:0] MinL = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] MaxL = LEN_W'(MAX_LEN);

   assign len_ok = (raw_len != '0) && (raw_len <= MaxL);

   generate
      if (PAD_EN) begin : g_pad
         assign eff_len = (raw_len < MinL) ? MinL : raw_len;
      end else begin : g_nopad
         assign eff_len = raw_len;
      end
   endgenerate
endmodule

// File: rtl/txr_ptr_regs.sv
module txr_ptr_regs #(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_we,
   input  logic [AW-1:0] base_in,
   input  logic          idle,
   input  logic          advance,
   input  logic          wrap,
   output logic [AW-1:0] cur_ptr
);
   localparam logic [AW-1:0] Step = AW'(DESC_BYTES);
   localparam logic [AW-1:0] Mask = ~(Step - AW'(1));

   logic [AW-1:0] base_q, base_nxt, aligned;

   assign aligned  = base_in & Mask;
   assign base_nxt = base_we ? aligned : base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         cur_ptr <= '0;
      end else begin
         base_q <= base_nxt;
         if (advance)
            cur_ptr <= wrap ? base_nxt : cur_ptr + Step;
         else if (idle && base_we)
            cur_ptr <= aligned;
      end
   end

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !wrap |=> cur_ptr == $past(cur_ptr) + Step);
   p_slot_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !advance && !idle |=> $stable(cur_ptr));
endmodule

// File: rtl/txr_walk_fsm.sv
module txr_walk_fsm
   import txr_pkg::*;
#(
   parameter int AW      = 32,
   parameter int LEN_W   = 11,
   parameter int OWN_BIT = 31,
   parameter int EOR_BIT = 31,
   parameter int FS_BIT  = 29,
   parameter int LS_BIT  = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll,
   input  logic [AW-1:0]    cur_ptr,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   output logic [LEN_W-1:0] raw_len,
   input  logic             len_ok,
   input  logic [LEN_W-1:0] eff_len,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [LEN_W-1:0] tx_len,
   output logic [AW-1:0]    tx_addr,
   output logic             tx_first,
   output logic             tx_last,
   output logic             done,
   output logic             idle,
   output logic             advance,
   output logic             wrap
);
   txr_state_e    state;
   logic          pend;
   logic [DW-1:0] ctl_q;
   logic          eor_q, fs_q, ls_q;
   logic [AW-1:0] buf_q;
   logic          owned, restart;

   assign owned   = mem_rdata[OWN_BIT];
   assign restart = pend || poll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pend    <= 1'b0;
         ctl_q   <= '0;
         raw_len <= '0;
         eor_q   <= 1'b0;
         fs_q    <= 1'b0;
         ls_q    <= 1'b0;
         buf_q   <= '0;
      end else begin
         if (state == ST_CHK_CTL && !owned)
            pend <= 1'b0;
         else if (poll && state != ST_IDLE)
            pend <= 1'b1;
         unique case (state)
            ST_IDLE:    if (poll) state <= ST_RD_CTL;
            ST_RD_CTL:  state <= ST_CHK_CTL;
            ST_CHK_CTL: begin
               if (owned) begin
                  ctl_q <= mem_rdata;
                  state <= ST_RD_LEN;
               end else begin
                  state <= restart ? ST_RD_CTL : ST_IDLE;
               end
            end
            ST_RD_LEN:  state <= ST_GET_LEN;
            ST_GET_LEN: begin
               raw_len <= mem_rdata[LEN_W-1:0];
               eor_q   <= mem_rdata[EOR_BIT];
               fs_q    <= mem_rdata[FS_BIT];
               ls_q    <= mem_rdata[LS_BIT];
               state   <= ST_RD_BUF;
            end
            ST_RD_BUF:  state <= ST_GET_BUF;
            ST_GET_BUF: begin
               buf_q <= mem_rdata[AW-1:0];
               state <= len_ok ? ST_SEND : ST_RETURN;
            end
            ST_SEND:    if (tx_ready) state <= ST_RETURN;
            ST_RETURN:  state <= ST_RD_CTL;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = cur_ptr + AW'(OFS_CTL);
      unique case (state)
         ST_RD_CTL: mem_req = 1'b1;
         ST_RD_LEN: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(OFS_LEN); end
         ST_RD_BUF: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(OFS_BUF); end
         ST_RETURN: begin mem_req = 1'b1; mem_we = 1'b1; end
         default: ;
      endcase
   end

   assign mem_wdata = ctl_q & ~(DW'(1) << OWN_BIT);
   assign tx_valid  = (state == ST_SEND);
   assign tx_len    = eff_len;
   assign tx_addr   = buf_q;
   assign tx_first  = fs_q;
   assign tx_last   = ls_q;
   assign done      = (state == ST_CHK_CTL) && !owned && !restart;
   assign idle      = (state == ST_IDLE);
   assign advance   = (state == ST_RETURN);
   assign wrap      = eor_q;

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idle && poll |=> mem_req && !mem_we);
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !mem_req);
   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_len) && $stable(tx_addr));
   p_wb_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[OWN_BIT]);
   p_no_skip_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> len_ok);
endmodule

// File: rtl/txr_ring_walker.sv
module txr_ring_walker #(
   parameter int AW         = 32,
   parameter int LEN_W      = 11,
   parameter int MIN_LEN    = 60,
   parameter int MAX_LEN    = 1536,
   parameter int DESC_BYTES = 16,
   parameter bit PAD_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [LEN_W-1:0] tx_len,
   output logic [AW-1:0]    tx_addr,
   output logic             tx_first,
   output logic             tx_last,
   output logic             done
);
   generate
      if (MAX_LEN >= (1 << LEN_W) || MIN_LEN > MAX_LEN) begin : g_bad_len
         $error("txr_ring_walker: length limits do not fit LEN_W");
      end
      if (DESC_BYTES < 16 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_desc
         $error("txr_ring_walker: DESC_BYTES must be a power of two >= 16");
      end
      if (AW > 32 || AW < 8) begin : g_bad_aw
         $error("txr_ring_walker: AW must lie in 8..32");
      end
   endgenerate

   logic             poll, base_we, idle, advance, wrap, len_ok;
   logic [AW-1:0]    cur_ptr;
   logic [LEN_W-1:0] raw_len, eff_len;

   assign poll    = cfg_we && cfg_sel;
   assign base_we = cfg_we && !cfg_sel;

   txr_ptr_regs #(.AW(AW), .DESC_BYTES(DESC_BYTES)) i_ptr (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_in(cfg_wdata),
      .idle(idle), .advance(advance), .wrap(wrap), .cur_ptr(cur_ptr));

   txr_len_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .PAD_EN(PAD_EN)) i_len (
      .raw_len(raw_len), .len_ok(len_ok), .eff_len(eff_len));

   txr_walk_fsm #(.AW(AW), .LEN_W(LEN_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .poll(poll), .cur_ptr(cur_ptr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .raw_len(raw_len), .len_ok(len_ok), .eff_len(eff_len),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len),
      .tx_addr(tx_addr), .tx_first(tx_first), .tx_last(tx_last),
      .done(done), .idle(idle), .advance(advance), .wrap(wrap));

   p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (PAD_EN == 1'b0 || tx_len >= LEN_W'(MIN_LEN)) && tx_len <= LEN_W'(MAX_LEN));
endmodule

// File: tb/test_txr_ring_walker.sv
`timescale 1ns/1ps
module test_txr_ring_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        tx_valid, tx_first, tx_last, done;
   logic        tx_ready = 1'b1;
   logic [10:0] tx_len;
   logic [31:0] tx_addr;

   always #2 clk = ~clk;

   txr_ring_walker i_txr_ring_walker (.*);

   // memory model: 128 words, one-cycle read latency
   logic [31:0] mem [128];
   logic        bw_en = 1'b0;
   logic [31:0] bw_addr = '0, bw_data = '0;
   logic [31:0] watch_a = 32'hFFFF_FFFF, watch_b = 32'hFFFF_FFFF;
   int          cnt_a = 0, cnt_b = 0, done_cnt = 0, fl_n = 0;
   logic [10:0] fl_len [32];
   logic [31:0] fl_addr [32];
   logic        fl_fs [32];
   logic        fl_ls [32];

   initial for (int i = 0; i < 128; i++) mem[i] = '0;

   always @(posedge clk) begin
      if (bw_en) mem[bw_addr[8:2]] <= bw_data;
      else if (mem_req && mem_we) mem[mem_addr[8:2]] <= mem_wdata;
      if (mem_req && !mem_we) begin
         mem_rdata <= mem[mem_addr[8:2]];
         if (mem_addr == watch_a) cnt_a <= cnt_a + 1;
         if (mem_addr == watch_b) cnt_b <= cnt_b + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
      if (tx_valid && tx_ready && fl_n < 32) begin
         fl_len[fl_n]  <= tx_len;
         fl_addr[fl_n] <= tx_addr;
         fl_fs[fl_n]   <= tx_first;
         fl_ls[fl_n]   <= tx_last;
         fl_n          <= fl_n + 1;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] a, input logic [31:0] d);
      bw_en = 1'b1; bw_addr = a; bw_data = d;
      @(posedge clk); #1 bw_en = 1'b0;
   endtask

   task automatic cfg(input logic sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); #1 cfg_we = 1'b0;
   endtask

   task automatic wait_done(input int d0);
      for (int k = 0; k < 400 && done_cnt == d0; k++) @(posedge clk);
      @(negedge clk);
   endtask

   localparam logic [31:0] OWN = 32'h8000_0000;
   localparam logic [31:0] EOR = 32'h8000_0000;
   localparam logic [31:0] FS  = 32'h2000_0000;
   localparam logic [31:0] LS  = 32'h1000_0000;

   // {raw len, first, last, expect sent, expect len}
   localparam logic [24:0] VEC [8] = '{
      {11'd100,  1'b1, 1'b1, 1'b1, 11'd100},
      {11'd59,   1'b1, 1'b0, 1'b1, 11'd60},
      {11'd1,    1'b0, 1'b1, 1'b1, 11'd60},
      {11'd60,   1'b1, 1'b1, 1'b1, 11'd60},
      {11'd1536, 1'b1, 1'b1, 1'b1, 11'd1536},
      {11'd1537, 1'b1, 1'b1, 1'b0, 11'd0},
      {11'd0,    1'b1, 1'b1, 1'b0, 11'd0},
      {11'd2047, 1'b0, 1'b0, 1'b0, 11'd0}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int f0, d0, a0, b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!mem_req && !tx_valid && !done, "R1 reset idle", {mem_req, tx_valid, done}, 0);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk); #1;

      // table walk: one-descriptor ring at 0x40 (base written with stray low bits)
      watch_a = 32'h40;
      for (int i = 0; i < 8; i++) begin
         logic [10:0] rl, el;
         logic        fs, ls, es;
         {rl, fs, ls, es, el} = VEC[i];
         put(32'h40, OWN | 32'h55);
         put(32'h44, EOR | (fs ? FS : 0) | (ls ? LS : 0) | 32'(rl));
         put(32'h48, 32'h1000 + 32'(i) * 32'h100);
         cfg(1'b0, 32'h43);
         f0 = fl_n; d0 = done_cnt; a0 = cnt_a;
         cfg(1'b1, 32'hDEAD_BEEF);
         wait_done(d0);
         check(fl_n - f0 == int'(es), es ? "R5 frame sent" : "R6 frame skipped", fl_n - f0, es);
         if (es && fl_n > f0) begin
            check(fl_len[f0] == el, "R5 padded length", fl_len[f0], el);
            check(fl_addr[f0] == 32'h1000 + 32'(i) * 32'h100, "R4 buffer address",
                  fl_addr[f0], 32'h1000 + i * 32'h100);
            check(fl_fs[f0] == fs && fl_ls[f0] == ls, "R4 segment flags",
                  {fl_fs[f0], fl_ls[f0]}, {fs, ls});
         end
         check(mem[16] == 32'h55, "R7 write-back clears owner", mem[16], 32'h55);
         check(cnt_a - a0 == 2, "R8 wrap to aligned base (R2)", cnt_a - a0, 2);
      end

      // software-owned slot: immediate stop
      watch_a = 32'h100;
      cfg(1'b0, 32'h100);
      f0 = fl_n; d0 = done_cnt; a0 = cnt_a;
      cfg(1'b1, 32'h0);
      wait_done(d0);
      repeat (3) @(negedge clk);
      check(fl_n == f0 && mem[64] == 0, "R3 no frame no write", fl_n - f0, 0);
      check(cnt_a - a0 == 1 && done_cnt - d0 == 1, "R3 single read and done", cnt_a - a0, 1);

      // three-slot ring with stalled handoff
      put(32'h80, OWN); put(32'h84, FS | LS | 32'd200); put(32'h88, 32'h2000);
      put(32'h90, OWN); put(32'h94, FS | 32'd300);      put(32'h98, 32'h3000);
      put(32'hA0, OWN); put(32'hA4, EOR | LS | 32'd40); put(32'hA8, 32'h4000);
      watch_a = 32'h80;
      cfg(1'b0, 32'h80);
      tx_ready = 1'b0;
      f0 = fl_n; d0 = done_cnt; a0 = cnt_a;
      cfg(1'b1, 32'h1);
      repeat (15) @(negedge clk);
      check(tx_valid && tx_len == 11'd200 && tx_addr == 32'h2000, "R4 offer held while not ready",
            {tx_valid, tx_len}, {1'b1, 11'd200});
      #1 tx_ready = 1'b1;
      wait_done(d0);
      check(fl_n - f0 == 3, "R8 three frames", fl_n - f0, 3);
      if (fl_n - f0 == 3) begin
         check(fl_len[f0+1] == 11'd300 && fl_addr[f0+1] == 32'h3000, "R8 second slot", fl_len[f0+1], 300);
         check(fl_len[f0+2] == 11'd60 && fl_addr[f0+2] == 32'h4000, "R5 third slot padded", fl_len[f0+2], 60);
      end
      check(mem[32] == 0 && mem[36] == 0 && mem[40] == 0, "R7 all returned", {mem[32], mem[36], mem[40]}, 0);
      check(cnt_a - a0 == 2, "R8 ring end returns to base", cnt_a - a0, 2);

      // poll during a stalled handoff
      put(32'hC0, OWN); put(32'hC4, FS | LS | 32'd80); put(32'hC8, 32'h5000);
      put(32'hD0, 32'h0);
      watch_b = 32'hD0;
      cfg(1'b0, 32'hC0);
      tx_ready = 1'b0;
      d0 = done_cnt; b0 = cnt_b;
      cfg(1'b1, 32'h0);
      repeat (10) @(posedge clk);
      #1 cfg(1'b1, 32'h0);
      tx_ready = 1'b1;
      wait_done(d0);
      repeat (3) @(negedge clk);
      check(cnt_b - b0 == 2, "R9 pending poll rereads slot", cnt_b - b0, 2);
      check(done_cnt - d0 == 1, "R9 one done pulse", done_cnt - d0, 1);

      // poll in the very cycle the stop decision is made
      put(32'hC0, OWN);
      cfg(1'b0, 32'hC0);
      d0 = done_cnt; b0 = cnt_b;
      cfg(1'b1, 32'h0);
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (mem_req && !mem_we && mem_addr == 32'hD0) break;
      end
      @(posedge clk); #1 cfg(1'b1, 32'h0);
      wait_done(d0);
      repeat (3) @(negedge clk);
      check(cnt_b - b0 == 2, "R9 same-cycle poll rereads slot", cnt_b - b0, 2);
      check(done_cnt - d0 == 1, "R9 same-cycle one done", done_cnt - d0, 1);

      // base write during walk
      put(32'h40, OWN | 32'h7); put(32'h44, EOR | 32'd70); put(32'h48, 32'h6000);
      watch_a = 32'h40; watch_b = 32'h100;
      cfg(1'b0, 32'h40);
      tx_ready = 1'b0;
      d0 = done_cnt; a0 = cnt_a; b0 = cnt_b;
      cfg(1'b1, 32'h0);
      repeat (10) @(posedge clk);
      #1 cfg(1'b0, 32'h100);
      tx_ready = 1'b1;
      wait_done(d0);
      check(mem[16] == 32'h7, "R10 write-back at old slot", mem[16], 32'h7);
      check(cnt_a - a0 == 1 && cnt_b - b0 == 1, "R10 wrap uses new base", {cnt_a - a0, cnt_b - b0}, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule